// File: doc/BRIEF.md
# DRAM controller configuration register bank with key lock

This block holds the software-visible control words of a DRAM controller. A plain word-wide register bus reaches it through a select, a write enable, a word address, write data and registered read data. Word 0 holds a protection key. While that word does not hold the unlock value 0xFC600309, every write aimed at another word is thrown away, and a one-cycle error pulse marks the refused access. Writing any other value to word 0 locks the bank again.

Word 1 is the configuration word. Some of its fields are fixed status or reserved bits that software cannot change. Which bits these are depends on a chip-variant parameter. The reset value of word 1 is built from the variant and from a memory-size parameter given in megabytes. That size is turned into a two-bit size code, and a size that is not supported falls back to a default code. Nothing here drives DRAM pins: the block only stores, locks, masks and resets the words.

The bus has no back-pressure. An access is a single cycle with the select high. It is always accepted, and the bus never stalls. Read data shows on the output one cycle after a read select and is then held until the next read.

Top module: `dram_cfg_bank`

## Requirements
- R1: After reset every word reads 0 except word 1, the error pulse is low, and the read data output is 0.
- R2: Word 1 resets, for variant 0, to bit 6 set plus the size code in bits 1:0. For variant 1 it resets to 1 in bits 31:28, 3 in bits 3:2 and the size code in bits 1:0.
- R3: The size code is made as follows. Variant 0 encodes 64/128/256/512 MB as 0/1/2/3, and any other size gives code 2. Variant 1 encodes 128/256/512/1024 MB as 0/1/2/3, and any other size gives code 2.
- R4: A write to word 0 always takes effect, locked or not, and raises no error.
- R5: While word 0 differs from 0xFC600309, a write to an in-range word other than 0 leaves all storage unchanged. The error output is then high in the cycle after the write, for that one cycle.
- R6: While word 0 equals 0xFC600309, writes to in-range words take effect and raise no error.
- R7: Writing word 0 with any value other than the key locks the bank for the very next access.
- R8: On a permitted write to word 1, the read-only bits keep their stored value and all other bits take the written data. The read-only mask is 0xFFFFF84C for variant 0 and 0xF00FC04C for variant 1.
- R9: Read data is registered: it shows the addressed word one cycle after a read select. A read of word index NUM_REGS or higher returns 0.
- R10: A write to word index NUM_REGS or higher is ignored and raises no error, even when the bank is locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lock_err | output | 1 | One-cycle pulse after a write refused by the lock |

## Verification
The bench aims at several corner cases, each of which exposes a different fault:
- A write to word 1 just after the key is replaced by a wrong value. A bank that re-locks one access late would let this write land.
- All ones and all zeros written into word 1 on both variants. A wrong or swapped mask lets fixed status bits move.
- Writes just past the top word while the bank is locked. A range check placed after the lock check would raise a false error here.
- A memory size that is not supported. A missing fallback would reset the size field to something other than code 2.

Random traffic keeps toggling the lock between these directed cases.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

  localparam logic [31:0] UNLOCK_WORD = 32'hFC600309;
  localparam int          CONF_IDX    = 1;

  function automatic logic [1:0] size_code(input int variant, input int mem_mb);
    logic [1:0] c;
    c = 2'd2;
    if (variant == 0) begin
      case (mem_mb)
        64:      c = 2'd0;
        128:     c = 2'd1;
        256:     c = 2'd2;
        512:     c = 2'd3;
        default: c = 2'd2;
      endcase
    end else begin
      case (mem_mb)
        128:     c = 2'd0;
        256:     c = 2'd1;
        512:     c = 2'd2;
        1024:    c = 2'd3;
        default: c = 2'd2;
      endcase
    end
    return c;
  endfunction

  function automatic logic [31:0] conf_ro_mask(input int variant);
    logic [31:0] m;
    m = 32'h0000_004C;                  // bit 6 and bits 3:2 in both variants
    if (variant == 0) m |= 32'hFFFF_F800; // upper reserved span
    else              m |= 32'hF00F_C000; // version, init status, reserved
    return m;
  endfunction

  function automatic logic [31:0] conf_reset(input int variant, input int mem_mb);
    logic [31:0] v;
    v = {30'd0, size_code(variant, mem_mb)};
    if (variant == 0) v |= 32'h0000_0040;
    else              v |= 32'h1000_000C;
    return v;
  endfunction

endpackage

// File: rtl/dcfg_access.sv
module dcfg_access
  import dcfg_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = 10,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       key_word,
  output logic              wr_en,
  output logic              rd_en,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              lock_err
);

  logic open_bank;
  logic is_key;
  logic refused;

  assign hit       = addr < ADDR_W'(NUM_REGS);
  assign idx       = addr[IDX_W-1:0];
  assign open_bank = (key_word == UNLOCK_WORD);
  assign is_key    = (idx == '0);
  assign wr_en     = sel && we && hit && (is_key || open_bank);
  assign rd_en     = sel && !we;
  assign refused   = sel && we && hit && !is_key && !open_bank;

  always_ff @(posedge clk) begin
    if (!rst_n) lock_err <= 1'b0;
    else        lock_err <= refused;
  end

  // R10: out-of-window writes never flag an error
  p_oob_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && (addr >= ADDR_W'(NUM_REGS))) |=> !lock_err);

  // R4: the key word is reachable whatever the lock state
  p_key_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we && (addr == '0)) |-> wr_en);

endmodule

// File: rtl/dcfg_store.sv
module dcfg_store
  import dcfg_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int VARIANT  = 1,
  parameter int MEM_MB   = 512,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      words [NUM_REGS]
);

  localparam logic [31:0] RO_MASK  = conf_ro_mask(VARIANT);
  localparam logic [31:0] CONF_RST = conf_reset(VARIANT, MEM_MB);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
    localparam logic [31:0] RST_VAL = (i == CONF_IDX) ? CONF_RST : 32'd0;
    localparam logic [31:0] WR_MASK = (i == CONF_IDX) ? ~RO_MASK : 32'hFFFF_FFFF;
    always_ff @(posedge clk) begin
      if (!rst_n)
        words[i] <= RST_VAL;
      else if (wr_en && (wr_idx == IDX_W'(i)))
        words[i] <= (words[i] & ~WR_MASK) | (wdata & WR_MASK);
    end
  end

  // R4: a write to word 0 lands as written
  p_key_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == '0)) |=> (words[0] == $past(wdata)));

  // R8: fixed bits of the configuration word never move
  p_conf_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((words[CONF_IDX] & RO_MASK) == ($past(words[CONF_IDX]) & RO_MASK)));

  // R5: with the key absent only word 0 may be written
  p_locked_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((words[0] != UNLOCK_WORD) && wr_en) |-> (wr_idx == '0));

endmodule

// File: rtl/dcfg_rdport.sv
module dcfg_rdport #(
  parameter int NUM_REGS = 64,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      words [NUM_REGS],
  output logic [31:0]      rdata
);

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= hit ? words[idx] : 32'd0;
  end

  // R9: reads outside the bank return zero
  p_oob_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (rdata == 32'd0));

  // R9: read data holds between reads
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/dram_cfg_bank.sv
module dram_cfg_bank #(
  parameter int VARIANT  = 1,
  parameter int MEM_MB   = 512,
  parameter int NUM_REGS = 64,
  parameter int ADDR_W   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              lock_err
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic             wr_en;
  logic             rd_en;
  logic             hit;
  logic [IDX_W-1:0] idx;
  logic [31:0]      words [NUM_REGS];

  dcfg_access #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_access (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .key_word (words[0]),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .hit      (hit),
    .idx      (idx),
    .lock_err (lock_err)
  );

  dcfg_store #(.NUM_REGS(NUM_REGS), .VARIANT(VARIANT), .MEM_MB(MEM_MB)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (idx),
    .wdata  (bus_wdata),
    .words  (words)
  );

  dcfg_rdport #(.NUM_REGS(NUM_REGS)) u_rdport (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_en (rd_en),
    .hit   (hit),
    .idx   (idx),
    .words (words),
    .rdata (bus_rdata)
  );

  // R5: a refused write is a single-cycle pulse unless refused again
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_err && !bus_sel) |=> !lock_err);

endmodule

// File: tb/dram_cfg_bank_test.sv
`timescale 1ns/1ps
module dram_cfg_bank_test;

  localparam int NR = 64;
  localparam logic [31:0] KEY = 32'hFC600309;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd [3];
  logic        err [3];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          var_of [3] = '{1, 0, 1};
  int          mb_of  [3] = '{512, 100, 1024};
  logic [31:0] model [3][NR];

  always #2 clk = ~clk;

  dram_cfg_bank #(.VARIANT(1), .MEM_MB(512)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[0]), .lock_err(err[0]));
  dram_cfg_bank #(.VARIANT(0), .MEM_MB(100)) uut_a (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[1]), .lock_err(err[1]));
  dram_cfg_bank #(.VARIANT(1), .MEM_MB(1024)) uut_c (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rd[2]), .lock_err(err[2]));

  function automatic logic [1:0] exp_code(int v, int mb);
    if (v == 0) return (mb == 64) ? 2'd0 : (mb == 128) ? 2'd1 : (mb == 512) ? 2'd3 : 2'd2;
    return (mb == 128) ? 2'd0 : (mb == 256) ? 2'd1 : (mb == 1024) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [31:0] exp_mask(int v);
    return (v == 0) ? 32'hFFFFF84C : 32'hF00FC04C;
  endfunction

  function automatic logic [31:0] exp_conf(int v, int mb);
    logic [31:0] r;
    r = {30'd0, exp_code(v, mb)};
    if (v == 0) r[6] = 1'b1;
    else begin r[31:28] = 4'd1; r[3:2] = 2'd3; end
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < NR; j++) model[k][j] = '0;
      model[k][1] = exp_conf(var_of[k], mb_of[k]);
    end
  endtask

  // one bus access, then checks one cycle later
  task automatic op(bit w, int a, logic [31:0] d, string req);
    logic        e_err [3];
    logic [31:0] e_rd  [3];
    for (int k = 0; k < 3; k++) begin
      e_err[k] = 1'b0;
      e_rd[k]  = 32'd0;
      if (a < NR) begin
        if (!w) e_rd[k] = model[k][a];
        else if (a == 0) model[k][0] = d;
        else if (model[k][0] == KEY) begin
          if (a == 1) model[k][1] = (model[k][1] & exp_mask(var_of[k])) | (d & ~exp_mask(var_of[k]));
          else        model[k][a] = d;
        end else e_err[k] = 1'b1;
      end
    end
    sel = 1'b1; we = w; addr = 10'(a); wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(req, $sformatf("inst%0d err a=%0d", k, a), {31'd0, err[k]}, {31'd0, e_err[k]});
      if (!w) chk(req, $sformatf("inst%0d rd a=%0d", k, a), rd[k], e_rd[k]);
    end
  endtask

  task automatic idle_chk(string req);
    @(negedge clk);
    for (int k = 0; k < 3; k++) chk(req, "err after idle", {31'd0, err[k]}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r, a;
    logic [31:0] d;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      chk("R1", "rdata reset", rd[k], 32'd0);
      chk("R1", "err reset", {31'd0, err[k]}, 32'd0);
    end
    // R2 / R3 reset contents of the configuration word
    op(0, 1, 0, "R2");
    chk("R3", "code var1 512", {30'd0, rd[0][1:0]}, 32'd2);
    chk("R3", "code var0 fallback", {30'd0, rd[1][1:0]}, 32'd2);
    chk("R3", "code var1 1024", {30'd0, rd[2][1:0]}, 32'd3);
    op(0, 5, 0, "R1");
    op(0, 0, 0, "R1");
    // R5 locked write refused, pulse one cycle
    op(1, 5, 32'h1234_5678, "R5");
    idle_chk("R5");
    op(0, 5, 0, "R5");
    op(1, 1, 32'hFFFF_FFFF, "R5");
    op(0, 1, 0, "R5");
    // R10 out of range write while locked
    op(1, 64, 32'hDEAD_BEEF, "R10");
    op(1, 1023, 32'hDEAD_BEEF, "R10");
    // R4 key always writable
    op(1, 0, KEY, "R4");
    op(0, 0, 0, "R4");
    // R6 unlocked writes
    op(1, 5, 32'hA5A5_0F0F, "R6");
    op(0, 5, 0, "R6");
    op(1, 63, 32'h0BAD_CAFE, "R6");
    op(0, 63, 0, "R6");
    // R8 masking both directions
    op(1, 1, 32'hFFFF_FFFF, "R8");
    op(0, 1, 0, "R8");
    op(1, 1, 32'h0000_0000, "R8");
    op(0, 1, 0, "R8");
    // R9 out of range reads
    op(0, 64, 0, "R9");
    op(0, 1023, 0, "R9");
    // R7 relock takes effect on the next access
    op(1, 0, 32'hFC60_0308, "R7");
    op(1, 1, 32'h0000_07B0, "R7");
    op(0, 1, 0, "R7");
    op(1, 0, KEY, "R7");
    op(1, 0, 32'd0, "R7");
    op(1, 5, 32'h1111_1111, "R7");
    op(0, 5, 0, "R7");
    // random traffic with fixed seed
    r = $urandom(32'd20240611);
    for (int n = 0; n < 3000; n++) begin
      r = $urandom % 10;
      d = $urandom;
      if (r < 2)      begin a = 0; if ($urandom % 2 == 0) d = KEY; end
      else if (r < 4) a = 1;
      else if (r < 8) a = $urandom % NR;
      else if (r < 9) a = 60 + $urandom % 11;
      else            a = $urandom % 1024;
      op(($urandom % 2) == 1, a, d, "R6");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule